// File: doc/BRIEF.md
# Interrupt Vectoring and Context-Save Unit

This unit sits next to a 32-bit in-order pipeline and decides, each cycle, whether control flow must be diverted to an interrupt handler or back from one. Request lines come in one per interrupt source. When a request is enabled and wins arbitration, the unit saves the resume PC and the current machine state into a save/restore pair. It then issues a one-cycle redirect that carries the handler address and the masked machine state the pipeline must adopt.

The unit has two save/restore pairs. Pair A (slots 0 and 1) serves ordinary interrupts, and pair B (slots 2 and 3) serves critical ones, so a critical event taken inside an ordinary handler does not destroy the ordinary return context. Two return strobes, one per class, redirect back to the saved PC and state. The handler address is the upper half of a software-written vector prefix register joined to a fixed 16-bit offset per interrupt type. Sources of the same type share one address.

The pipeline loads the machine state from `msr_out` on the redirect cycle, and the new state applies from the first handler instruction.

Top module: `irq_vector_unit`

## Requirements
- R1: `irq_req` index order sets priority. Indices 0 to 3 are critical, indices 4 to 14 are noncritical, and the lowest enabled index wins. At most one event is taken per cycle.
- R2: The redirect address on an interrupt is `{prefix[31:16], offset}`. The offsets by index are: 0:0x0100, 1:0x0200, 2:0x0200, 3:0x1020, 4:0x0300, 5:0x0400, 6:0x0500, 7:0x0600, 8:0x0700, 9:0x0800, 10:0x0C00, 11:0x0F20, 12:0x1000, 13:0x1010, 14:0x1100.
- R3: A noncritical interrupt stores `cur_pc` into slot 0 and `cur_msr` into slot 1. Slots 2 and 3 keep their values.
- R4: A critical interrupt stores `cur_pc` into slot 2 and `cur_msr` into slot 3. Slots 0 and 1 keep their values.
- R5: The redirect cycle's `msr_out` is `cur_msr` as it was at acceptance, with bit 15 (external enable) cleared for a noncritical interrupt and with bits 15 and 17 (critical enable) both cleared for a critical one.
- R6: Noncritical requests are ignored while `cur_msr[15]` is 0. Critical requests are ignored while `cur_msr[17]` is 0.
- R7: `rfi` redirects to slot 0 and loads `msr_out` from slot 1. `rfci` does the same from slots 2 and 3. `rfci` beats `rfi`, and either return beats an interrupt in the same cycle.
- R8: `redirect_valid` rises in the cycle after acceptance and stays high for exactly one cycle. No event is accepted while it is high.
- R9: The prefix register resets to 0 and changes only when `pfx_we` is high. An interrupt taken in the same cycle as a prefix write uses the old prefix.
- R10: After reset, `redirect_valid` is 0 and all four save slots hold 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 15 | Level request per interrupt source, index = priority |
| cur_pc | input | AW | Address at which to resume after the interrupt |
| cur_msr | input | MSR_W | Current machine state |
| pfx_we | input | 1 | Vector prefix write enable |
| pfx_wdata | input | AW | Vector prefix write data |
| rfi | input | 1 | Return from noncritical interrupt |
| rfci | input | 1 | Return from critical interrupt |
| redirect_valid | output | 1 | One-cycle redirect pulse |
| redirect_pc | output | AW | Target fetch address |
| msr_out | output | MSR_W | Machine state to load on the redirect |

## Verification
The bench uses the default parameters: 32-bit addresses and state, a 16-bit prefix, external enable at bit 15 and critical enable at bit 17. With these values, every offset in the table can be compared as a full 32-bit address, and the two enable bits can be set independently to block one class while the other still fires. Save-slot independence is observed only through the return strobes: nested critical and noncritical entries are interleaved so that each return shows whether the other class overwrote its slots.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    localparam int NUM_SRC  = 15;
    localparam int NUM_CRIT = 4;
    localparam int SRC_W    = $clog2(NUM_SRC);
    localparam int OFFS_W   = 16;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_IRQ,
        EV_RFI,
        EV_RFCI
    } ev_e;

    // Fixed handler offset per source index; sources of one type share a value.
    function automatic logic [OFFS_W-1:0] src_offset(input logic [SRC_W-1:0] idx);
        case (idx)
            4'd0:    return 16'h0100;
            4'd1:    return 16'h0200;
            4'd2:    return 16'h0200;
            4'd3:    return 16'h1020;
            4'd4:    return 16'h0300;
            4'd5:    return 16'h0400;
            4'd6:    return 16'h0500;
            4'd7:    return 16'h0600;
            4'd8:    return 16'h0700;
            4'd9:    return 16'h0800;
            4'd10:   return 16'h0C00;
            4'd11:   return 16'h0F20;
            4'd12:   return 16'h1000;
            4'd13:   return 16'h1010;
            4'd14:   return 16'h1100;
            default: return 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
    import irqv_pkg::*;
#(
    parameter int N_SRC  = NUM_SRC,
    parameter int N_CRIT = NUM_CRIT,
    localparam int IW    = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] req,
    input  logic             ext_en,
    input  logic             crit_en,
    output logic             grant_valid,
    output logic [IW-1:0]    grant_idx,
    output logic             grant_crit
);

    logic [N_SRC-1:0] elig;

    for (genvar g = 0; g < N_SRC; g++) begin : g_elig
        if (g < N_CRIT) begin : g_crit
            assign elig[g] = req[g] & crit_en;
        end else begin : g_norm
            assign elig[g] = req[g] & ext_en;
        end
    end

    always_comb begin
        grant_valid = |elig;
        grant_idx   = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (elig[i]) grant_idx = IW'(i);
        end
    end

    assign grant_crit = grant_valid && (grant_idx < IW'(N_CRIT));

endmodule

// File: rtl/irqv_vecgen.sv
module irqv_vecgen
    import irqv_pkg::*;
#(
    parameter int AW     = 32,
    parameter int PFX_W  = 16,
    localparam int LOW_W = AW - PFX_W
) (
    input  logic [AW-1:0]    prefix,
    input  logic [SRC_W-1:0] idx,
    output logic [AW-1:0]    vector
);

    logic [OFFS_W-1:0] offs;

    always_comb begin
        offs   = src_offset(idx);
        vector = {prefix[AW-1 -: PFX_W], LOW_W'(offs)};
    end

endmodule

// File: rtl/irqv_ctx.sv
module irqv_ctx
    import irqv_pkg::*;
#(
    parameter int AW     = 32,
    parameter int MSR_W  = 32,
    parameter int EE_BIT = 15,
    parameter int CE_BIT = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grant_valid,
    input  logic             grant_crit,
    input  logic [AW-1:0]    vector,
    input  logic             rfi,
    input  logic             rfci,
    input  logic [AW-1:0]    cur_pc,
    input  logic [MSR_W-1:0] cur_msr,
    input  logic             pfx_we,
    input  logic [AW-1:0]    pfx_wdata,
    output logic [AW-1:0]    prefix,
    output logic             redirect_valid,
    output logic [AW-1:0]    redirect_pc,
    output logic [MSR_W-1:0] msr_out
);

    typedef struct packed {
        logic [AW-1:0]    prefix;
        logic [AW-1:0]    save_pc_n;
        logic [MSR_W-1:0] save_st_n;
        logic [AW-1:0]    save_pc_c;
        logic [MSR_W-1:0] save_st_c;
        logic             rv;
        logic [AW-1:0]    rpc;
        logic [MSR_W-1:0] rmsr;
    } ctx_t;

    ctx_t ctx_d, ctx_q;
    ev_e  ev;

    always_comb begin
        ev = EV_NONE;
        if (!ctx_q.rv) begin
            if (rfci)             ev = EV_RFCI;
            else if (rfi)         ev = EV_RFI;
            else if (grant_valid) ev = EV_IRQ;
        end

        ctx_d    = ctx_q;
        ctx_d.rv = 1'b0;
        if (pfx_we) ctx_d.prefix = pfx_wdata;

        case (ev)
            EV_IRQ: begin
                ctx_d.rv   = 1'b1;
                ctx_d.rpc  = vector;
                ctx_d.rmsr = cur_msr;
                ctx_d.rmsr[EE_BIT] = 1'b0;
                if (grant_crit) begin
                    ctx_d.save_pc_c = cur_pc;
                    ctx_d.save_st_c = cur_msr;
                    ctx_d.rmsr[CE_BIT] = 1'b0;
                end else begin
                    ctx_d.save_pc_n = cur_pc;
                    ctx_d.save_st_n = cur_msr;
                end
            end
            EV_RFI: begin
                ctx_d.rv   = 1'b1;
                ctx_d.rpc  = ctx_q.save_pc_n;
                ctx_d.rmsr = ctx_q.save_st_n;
            end
            EV_RFCI: begin
                ctx_d.rv   = 1'b1;
                ctx_d.rpc  = ctx_q.save_pc_c;
                ctx_d.rmsr = ctx_q.save_st_c;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_d;
    end

    assign prefix         = ctx_q.prefix;
    assign redirect_valid = ctx_q.rv;
    assign redirect_pc    = ctx_q.rpc;
    assign msr_out        = ctx_q.rmsr;

endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
    import irqv_pkg::*;
#(
    parameter int AW     = 32,
    parameter int MSR_W  = 32,
    parameter int PFX_W  = 16,
    parameter int EE_BIT = 15,
    parameter int CE_BIT = 17
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [AW-1:0]      cur_pc,
    input  logic [MSR_W-1:0]   cur_msr,
    input  logic               pfx_we,
    input  logic [AW-1:0]      pfx_wdata,
    input  logic               rfi,
    input  logic               rfci,
    output logic               redirect_valid,
    output logic [AW-1:0]      redirect_pc,
    output logic [MSR_W-1:0]   msr_out
);

    logic             arb_valid;
    logic [SRC_W-1:0] arb_idx;
    logic             arb_crit;
    logic [AW-1:0]    vec_addr;
    logic [AW-1:0]    pfx_q;

    irqv_arbiter #(
        .N_SRC  (NUM_SRC),
        .N_CRIT (NUM_CRIT)
    ) u_arb (
        .req         (irq_req),
        .ext_en      (cur_msr[EE_BIT]),
        .crit_en     (cur_msr[CE_BIT]),
        .grant_valid (arb_valid),
        .grant_idx   (arb_idx),
        .grant_crit  (arb_crit)
    );

    irqv_vecgen #(
        .AW    (AW),
        .PFX_W (PFX_W)
    ) u_vec (
        .prefix (pfx_q),
        .idx    (arb_idx),
        .vector (vec_addr)
    );

    irqv_ctx #(
        .AW     (AW),
        .MSR_W  (MSR_W),
        .EE_BIT (EE_BIT),
        .CE_BIT (CE_BIT)
    ) u_ctx (
        .clk            (clk),
        .rst_n          (rst_n),
        .grant_valid    (arb_valid),
        .grant_crit     (arb_crit),
        .vector         (vec_addr),
        .rfi            (rfi),
        .rfci           (rfci),
        .cur_pc         (cur_pc),
        .cur_msr        (cur_msr),
        .pfx_we         (pfx_we),
        .pfx_wdata      (pfx_wdata),
        .prefix         (pfx_q),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .msr_out        (msr_out)
    );

endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
    parameter int AW     = 32,
    parameter int MSR_W  = 32,
    parameter int PFX_W  = 16,
    parameter int EE_BIT = 15,
    parameter int CE_BIT = 17
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arb_valid,
    input logic             arb_crit,
    input logic             rfi,
    input logic             rfci,
    input logic [MSR_W-1:0] cur_msr,
    input logic [AW-1:0]    pfx_q,
    input logic             redirect_valid,
    input logic [AW-1:0]    redirect_pc,
    input logic [MSR_W-1:0] msr_out
);

    logic take;
    assign take = arb_valid && !redirect_valid && !rfi && !rfci;

    p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !redirect_valid);

    p_crit_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_valid && arb_crit) |-> cur_msr[CE_BIT]);

    p_norm_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_valid && !arb_crit) |-> cur_msr[EE_BIT]);

    p_crit_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && arb_crit) |=> (redirect_valid && !msr_out[EE_BIT] && !msr_out[CE_BIT]));

    p_norm_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !arb_crit) |=> (redirect_valid && !msr_out[EE_BIT]
                                 && msr_out[CE_BIT] == $past(cur_msr[CE_BIT])));

    p_vec_prefix_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> redirect_pc[AW-1 -: PFX_W] == $past(pfx_q[AW-1 -: PFX_W]));

    p_return_fires_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((rfi || rfci) && !redirect_valid) |=> redirect_valid);

endmodule

bind irq_vector_unit irqv_checker #(
    .AW     (AW),
    .MSR_W  (MSR_W),
    .PFX_W  (PFX_W),
    .EE_BIT (EE_BIT),
    .CE_BIT (CE_BIT)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .arb_valid      (arb_valid),
    .arb_crit       (arb_crit),
    .rfi            (rfi),
    .rfci           (rfci),
    .cur_msr        (cur_msr),
    .pfx_q          (pfx_q),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .msr_out        (msr_out)
);

// File: tb/tb_irq_vector_unit.sv
module tb_irq_vector_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;
    localparam logic [31:0] EE = 32'h0000_8000;
    localparam logic [31:0] CE = 32'h0002_0000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [14:0] irq_req;
    logic [31:0] cur_pc, cur_msr, pfx_wdata;
    logic        pfx_we, rfi, rfci;
    logic        redirect_valid;
    logic [31:0] redirect_pc, msr_out;

    int tests = 0;
    int fails = 0;

    logic        o_v, o_v2;
    logic [31:0] o_pc, o_msr;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vector_unit dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .cur_pc(cur_pc),
        .cur_msr(cur_msr), .pfx_we(pfx_we), .pfx_wdata(pfx_wdata),
        .rfi(rfi), .rfci(rfci), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .msr_out(msr_out)
    );

    function automatic logic [15:0] exp_off(input int i);
        case (i)
            0: return 16'h0100;  1: return 16'h0200;  2: return 16'h0200;
            3: return 16'h1020;  4: return 16'h0300;  5: return 16'h0400;
            6: return 16'h0500;  7: return 16'h0600;  8: return 16'h0700;
            9: return 16'h0800; 10: return 16'h0C00; 11: return 16'h0F20;
            12: return 16'h1000; 13: return 16'h1010; 14: return 16'h1100;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Drive one cycle of stimulus, sample the redirect, then one idle cycle.
    task automatic cyc(input logic [14:0] r, input logic fi, input logic fci,
                       input logic we, input logic [31:0] wd);
        irq_req = r; rfi = fi; rfci = fci; pfx_we = we; pfx_wdata = wd;
        @(negedge clk);
        irq_req = '0; rfi = 1'b0; rfci = 1'b0; pfx_we = 1'b0;
        o_v = redirect_valid; o_pc = redirect_pc; o_msr = msr_out;
        @(negedge clk);
        o_v2 = redirect_valid;
    endtask

    task automatic t_reset;
        chk("R10 valid low after reset", {31'd0, redirect_valid}, 32'd0);
        cur_msr = EE | CE;
        cyc('0, 1'b1, 1'b0, 1'b0, '0);
        chk("R10 slot0 zero", o_pc, 32'h0);
        chk("R10 slot1 zero", o_msr, 32'h0);
        cyc('0, 1'b0, 1'b1, 1'b0, '0);
        chk("R10 slot2 zero", o_pc, 32'h0);
        chk("R10 slot3 zero", o_msr, 32'h0);
        cyc(15'h0040, 1'b0, 1'b0, 1'b0, '0);
        chk("R9 reset prefix zero", o_pc, 32'h0000_0500);
    endtask

    task automatic t_vectors;
        cyc('0, 1'b0, 1'b0, 1'b1, 32'hABCD_1234);
        chk("R9 write alone no redirect", {31'd0, o_v}, 32'd0);
        cur_msr = EE | CE | 32'h5;
        for (int i = 0; i < 15; i++) begin
            cyc(15'(1 << i), 1'b0, 1'b0, 1'b0, '0);
            chk($sformatf("R8 pulse src %0d", i), {31'd0, o_v}, 32'd1);
            chk($sformatf("R2 vector src %0d", i), o_pc, {16'hABCD, exp_off(i)});
            chk($sformatf("R5 state src %0d", i), o_msr,
                (i < 4) ? (cur_msr & ~(EE | CE)) : (cur_msr & ~EE));
            chk($sformatf("R8 pulse drop src %0d", i), {31'd0, o_v2}, 32'd0);
        end
        cyc(15'h0200, 1'b0, 1'b0, 1'b1, 32'h5A5A_0000);
        chk("R9 same-cycle write uses old prefix", o_pc, 32'hABCD_0800);
        cyc(15'h0200, 1'b0, 1'b0, 1'b0, '0);
        chk("R9 new prefix applied", o_pc, 32'h5A5A_0800);
    endtask

    task automatic t_priority;
        cur_msr = EE | CE;
        cyc(15'h7FFF, 1'b0, 1'b0, 1'b0, '0);
        chk("R1 all pending", o_pc, 32'h5A5A_0100);
        cyc(15'h4810, 1'b0, 1'b0, 1'b0, '0);
        chk("R1 noncritical lowest", o_pc, 32'h5A5A_0300);
        cyc(15'h000C, 1'b0, 1'b0, 1'b0, '0);
        chk("R1 machine check before watchdog", o_pc, 32'h5A5A_0200);
        cyc(15'h0018, 1'b0, 1'b0, 1'b0, '0);
        chk("R1 critical before noncritical", o_pc, 32'h5A5A_1020);
        cyc(15'h3000, 1'b0, 1'b0, 1'b0, '0);
        chk("R1 interval timers", o_pc, 32'h5A5A_1000);
    endtask

    task automatic t_masking;
        cur_msr = CE;
        cyc(15'h0040, 1'b0, 1'b0, 1'b0, '0);
        chk("R6 noncritical blocked", {31'd0, o_v}, 32'd0);
        cur_msr = EE;
        cyc(15'h0001, 1'b0, 1'b0, 1'b0, '0);
        chk("R6 critical blocked", {31'd0, o_v}, 32'd0);
        cyc(15'h0041, 1'b0, 1'b0, 1'b0, '0);
        chk("R6 noncritical passes critical blocked", o_pc, 32'h5A5A_0500);
        chk("R5 noncritical keeps CE", o_msr, 32'h0);
        cur_msr = CE;
        cyc(15'h0041, 1'b0, 1'b0, 1'b0, '0);
        chk("R6 critical passes", o_pc, 32'h5A5A_0100);
    endtask

    task automatic t_save;
        cur_msr = EE | CE | 32'h21; cur_pc = 32'h1111_0000;
        cyc(15'h0040, 1'b0, 1'b0, 1'b0, '0);
        chk("R5 noncritical state", o_msr, CE | 32'h21);
        cur_msr = EE | CE | 32'h40; cur_pc = 32'h2222_0004;
        cyc(15'h0001, 1'b0, 1'b0, 1'b0, '0);
        cyc('0, 1'b0, 1'b1, 1'b0, '0);
        chk("R7 rfci pc", o_pc, 32'h2222_0004);
        chk("R7 rfci state", o_msr, EE | CE | 32'h40);
        cyc('0, 1'b1, 1'b0, 1'b0, '0);
        chk("R7 rfi pc", o_pc, 32'h1111_0000);
        chk("R7 rfi state", o_msr, EE | CE | 32'h21);
        cur_msr = EE | CE | 32'h3; cur_pc = 32'h3333_0008;
        cyc(15'h0008, 1'b0, 1'b0, 1'b0, '0);
        cyc('0, 1'b1, 1'b0, 1'b0, '0);
        chk("R4 critical leaves slot0", o_pc, 32'h1111_0000);
        chk("R4 critical leaves slot1", o_msr, EE | CE | 32'h21);
        cur_msr = EE | CE | 32'h4; cur_pc = 32'h4444_000C;
        cyc(15'h0100, 1'b0, 1'b0, 1'b0, '0);
        cyc('0, 1'b0, 1'b1, 1'b0, '0);
        chk("R3 noncritical leaves slot2", o_pc, 32'h3333_0008);
        chk("R3 noncritical leaves slot3", o_msr, EE | CE | 32'h3);
    endtask

    task automatic t_return_prio;
        cur_msr = EE | CE;
        cyc('0, 1'b1, 1'b1, 1'b0, '0);
        chk("R7 rfci beats rfi", o_pc, 32'h3333_0008);
        cyc(15'h0001, 1'b1, 1'b0, 1'b0, '0);
        chk("R7 return beats interrupt pc", o_pc, 32'h4444_000C);
        chk("R7 return beats interrupt state", o_msr, EE | CE | 32'h4);
    endtask

    task automatic t_busy;
        cur_msr = EE | CE;
        irq_req = 15'h0020;
        @(negedge clk);
        o_v = redirect_valid; o_pc = redirect_pc;
        @(negedge clk);
        o_v2 = redirect_valid;
        irq_req = '0;
        chk("R8 held request taken", o_pc, 32'h5A5A_0400);
        chk("R8 no accept during pulse", {31'd0, o_v2}, 32'd0);
        @(negedge clk);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; irq_req = '0; cur_pc = '0; cur_msr = '0;
        pfx_we = 1'b0; pfx_wdata = '0; rfi = 1'b0; rfci = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_vectors();
        t_priority();
        t_masking();
        t_save();
        t_return_prio();
        t_busy();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule